// File: doc/BRIEF.md
# Timer Peripheral Bus Cycle Decoder

This block is the processor-facing side of a four-channel counter/timer peripheral on an 8-bit bus. Its control strobes are all active low. It has no write strobe. Each bus cycle is classified from the chip select, I/O request, read and first-machine-cycle inputs as one of four kinds: a register write, a counter read, an interrupt acknowledge, or a cycle the block must ignore, such as an instruction fetch. Each channel holds a simple loadable down-counter that is stepped by a tick input, so the bus side can be exercised without the full counting logic.

Writes are routed by a two-bit channel select. A byte with bit 0 set is a control word. Its bit 7 enables the channel's interrupt, and its bit 2 announces that the next write to that channel is a time constant. A byte with bit 0 clear, written to channel 0 while no time constant is expected, sets the interrupt vector base. Reads return the selected channel's live count.

During an interrupt acknowledge, the block answers only when its priority input is high and some channel is pending. It returns the vector of the lowest-numbered pending channel. That channel then moves from pending to in-service. A separate service-done pulse retires the highest-priority in-service channel. The priority output passes the chain onward only while this device is idle.

Top module: `tmr_bus_decoder`

## Requirements
- R1: A write is taken when ioreq_n=0, cs_n=0, rd_n=1 and m1_n=1. It is committed exactly once, at the first rising clock edge of that condition, however long the condition is held.
- R2: While ioreq_n=0, cs_n=0, rd_n=0 and m1_n=1, dout_en is 1 and dout equals the current count of the channel selected by ch_sel, in the same cycle.
- R3: A cycle with m1_n=0, rd_n=0 and ioreq_n=1 is an instruction fetch. It leaves dout_en at 0 and writes nothing.
- R4: A written byte with bit 0 = 1 is a control word: bit 7 = interrupt enable, bit 2 = time constant follows. When bit 2 was set, the next write to that channel loads both the reload value and the counter, whatever the byte's bit 0.
- R5: A byte with bit 0 = 0, written while no time constant is expected, stores bits 7:3 as the vector base when ch_sel=0. It is ignored for channels 1 to 3.
- R6: Each clock with tick[k]=1 decrements channel k's count. A tick at count 1 reloads the time constant instead, and sets the channel's pending flag if its interrupt is enabled.
- R7: An acknowledge (m1_n=0, ioreq_n=0, any cs_n) with iei=1 and a channel pending drives dout_en=1 and dout = {base[7:3], channel[1:0], 1'b0}, where the channel is the lowest-numbered pending one.
- R8: An acknowledge while iei=0, or while nothing is pending, leaves dout_en at 0 and pending state unchanged.
- R9: The first clock of an answered acknowledge clears the winner's pending flag and marks it in-service. The vector stays stable until the acknowledge ends.
- R10: ieo is 1 only when iei=1 and no channel is pending or in service.
- R11: A one-clock isr_done pulse clears the in-service flag of the lowest-numbered in-service channel.
- R12: After reset, all counts are 0 and nothing is pending. Outside reads and answered acknowledges, dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ioreq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | First machine cycle, active low |
| ch_sel | input | 2 | Channel select for reads and writes |
| din | input | 8 | Write data from the bus |
| tick | input | 4 | Per-channel count step |
| iei | input | 1 | Daisy-chain priority in |
| isr_done | input | 1 | Service finished pulse |
| dout | output | 8 | Data toward the bus |
| dout_en | output | 1 | Bus drive enable (low means high impedance) |
| ieo | output | 1 | Daisy-chain priority out |

## Verification
A wrong internal state reaches the ports at the next relevant bus cycle. A corrupted count or time constant shows up on the next read of that channel. A pending or in-service flag that is set wrongly or left stuck pulls ieo low in the same cycle. A lost flag shows up at the next acknowledge as a missing response or a wrong vector. A write that is committed twice becomes visible when a held control word turns into a time constant, which the following read of the count exposes.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
    localparam int unsigned NCH_DEF = 4;
    localparam int unsigned DW_DEF  = 8;

    // control word bit positions
    localparam int unsigned CW_MARK = 0;
    localparam int unsigned CW_TCF  = 2;
    localparam int unsigned CW_IE   = 7;

    typedef enum logic [1:0] {
        CYC_NONE,
        CYC_WRITE,
        CYC_READ,
        CYC_ACK
    } cyc_e;

    function automatic cyc_e classify(input logic m1_n, input logic ioreq_n,
                                      input logic rd_n, input logic cs_n);
        cyc_e c;
        c = CYC_NONE;
        if (!ioreq_n && !m1_n)
            c = CYC_ACK;
        else if (!ioreq_n && !cs_n && m1_n)
            c = rd_n ? CYC_WRITE : CYC_READ;
        return c;
    endfunction
endpackage

// File: rtl/tbd_cycle_decode.sv
module tbd_cycle_decode
    import tbd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic ioreq_n,
    input  logic rd_n,
    input  logic m1_n,
    output cyc_e cyc,
    output logic wr_commit,
    output logic ack_first
);
    logic wr_seen, ack_seen;

    always_comb begin
        cyc       = classify(m1_n, ioreq_n, rd_n, cs_n);
        wr_commit = (cyc == CYC_WRITE) && !wr_seen;
        ack_first = (cyc == CYC_ACK) && !ack_seen;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_seen  <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            wr_seen  <= (cyc == CYC_WRITE);
            ack_seen <= (cyc == CYC_ACK);
        end
    end
endmodule

// File: rtl/tbd_channel.sv
module tbd_channel
    import tbd_pkg::*;
#(
    parameter int unsigned DW = DW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          tick,
    input  logic          grant,
    input  logic          svc_clr,
    output logic [DW-1:0] count,
    output logic          pending,
    output logic          in_svc,
    output logic          plain_wr
);
    logic [DW-1:0] reload;
    logic          tc_wait;
    logic          ie;
    logic          expire;

    always_comb begin
        plain_wr = wr && !tc_wait && !wdata[CW_MARK];
        expire   = tick && !wr && (count == DW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload  <= '0;
            count   <= '0;
            tc_wait <= 1'b0;
            ie      <= 1'b0;
            pending <= 1'b0;
            in_svc  <= 1'b0;
        end else begin
            if (wr) begin
                if (tc_wait) begin
                    reload  <= wdata;
                    count   <= wdata;
                    tc_wait <= 1'b0;
                end else if (wdata[CW_MARK]) begin
                    ie      <= wdata[CW_IE];
                    tc_wait <= wdata[CW_TCF];
                end
            end else if (tick) begin
                count <= expire ? reload : count - DW'(1);
            end

            if (expire && ie)
                pending <= 1'b1;
            else if (grant)
                pending <= 1'b0;

            if (grant)
                in_svc <= 1'b1;
            else if (svc_clr)
                in_svc <= 1'b0;
        end
    end
endmodule

// File: rtl/tbd_prio.sv
module tbd_prio #(
    parameter int unsigned NCH  = 4,
    localparam int unsigned SELW = $clog2(NCH)
) (
    input  logic [NCH-1:0]  pending,
    input  logic [NCH-1:0]  in_svc,
    output logic [SELW-1:0] win_idx,
    output logic            any_pend,
    output logic [SELW-1:0] svc_idx,
    output logic            any_svc
);
    always_comb begin
        win_idx = '0;
        svc_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pending[i]) win_idx = SELW'(i);
            if (in_svc[i])  svc_idx = SELW'(i);
        end
        any_pend = |pending;
        any_svc  = |in_svc;
    end
endmodule

// File: rtl/tmr_bus_decoder.sv
module tmr_bus_decoder
    import tbd_pkg::*;
#(
    parameter int unsigned NCH  = NCH_DEF,
    parameter int unsigned DW   = DW_DEF,
    localparam int unsigned SELW = $clog2(NCH),
    localparam int unsigned BASE_LO = SELW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            ioreq_n,
    input  logic            rd_n,
    input  logic            m1_n,
    input  logic [SELW-1:0] ch_sel,
    input  logic [DW-1:0]   din,
    input  logic [NCH-1:0]  tick,
    input  logic            iei,
    input  logic            isr_done,
    output logic [DW-1:0]   dout,
    output logic            dout_en,
    output logic            ieo
);
    cyc_e            cyc;
    logic            wr_commit, ack_first;
    logic [DW-1:0]   count [NCH];
    logic [NCH-1:0]  pending, in_svc, plain_wr, grant, svc_clr;
    logic [SELW-1:0] win_idx, svc_idx, ack_idx, vec_idx;
    logic            any_pend, any_svc, ack_hold, answer;
    logic [DW-1:BASE_LO] vbase;

    tbd_cycle_decode u_dec (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ioreq_n(ioreq_n),
        .rd_n(rd_n), .m1_n(m1_n), .cyc(cyc),
        .wr_commit(wr_commit), .ack_first(ack_first)
    );

    tbd_prio #(.NCH(NCH)) u_prio (
        .pending(pending), .in_svc(in_svc), .win_idx(win_idx),
        .any_pend(any_pend), .svc_idx(svc_idx), .any_svc(any_svc)
    );

    always_comb begin
        answer = ack_first && iei && any_pend;
        for (int i = 0; i < NCH; i++) begin
            grant[i]   = answer && (win_idx == SELW'(i));
            svc_clr[i] = isr_done && any_svc && (svc_idx == SELW'(i));
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        tbd_channel #(.DW(DW)) u_ch (
            .clk(clk), .rst(rst),
            .wr(wr_commit && (ch_sel == SELW'(k))),
            .wdata(din), .tick(tick[k]), .grant(grant[k]),
            .svc_clr(svc_clr[k]), .count(count[k]),
            .pending(pending[k]), .in_svc(in_svc[k]),
            .plain_wr(plain_wr[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vbase    <= '0;
            ack_hold <= 1'b0;
            ack_idx  <= '0;
        end else begin
            if (plain_wr[0])
                vbase <= din[DW-1:BASE_LO];
            if (cyc != CYC_ACK) begin
                ack_hold <= 1'b0;
            end else if (answer) begin
                ack_hold <= 1'b1;
                ack_idx  <= win_idx;
            end
        end
    end

    always_comb begin
        vec_idx = ack_hold ? ack_idx : win_idx;
        dout    = '0;
        dout_en = 1'b0;
        case (cyc)
            CYC_READ: begin
                dout    = count[ch_sel];
                dout_en = 1'b1;
            end
            CYC_ACK: begin
                dout    = {vbase, vec_idx, 1'b0};
                dout_en = ack_hold || (iei && any_pend);
            end
            default: ;
        endcase
        ieo = iei && !any_pend && !any_svc;
    end
endmodule

// File: rtl/tbd_checker.sv
module tbd_checker #(
    parameter int unsigned NCH  = 4,
    parameter int unsigned DW   = 8,
    localparam int unsigned SELW = $clog2(NCH)
) (
    input logic            clk,
    input logic            rst,
    input logic            cs_n,
    input logic            ioreq_n,
    input logic            rd_n,
    input logic            m1_n,
    input logic            iei,
    input logic            ieo,
    input logic            dout_en,
    input logic [DW-1:0]   dout,
    input logic [NCH-1:0]  pending,
    input logic [NCH-1:0]  in_svc,
    input logic [SELW-1:0] win_idx,
    input logic            ack_hold
);
    logic ack_c;
    assign ack_c = !m1_n && !ioreq_n;

    p_read_drives_r2: assert property (@(posedge clk) disable iff (rst)
        (!ioreq_n && !cs_n && !rd_n && m1_n) |-> dout_en);

    p_fetch_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!m1_n && !rd_n && ioreq_n) |-> !dout_en);

    p_vec_lsb_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_c && dout_en) |-> !dout[0]);

    p_no_answer_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_c && !ack_hold && (pending == '0)) |-> !dout_en);

    p_grant_service_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_c && !ack_hold && iei && (pending != '0)) |=> in_svc[$past(win_idx)]);

    p_vec_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_c && $past(ack_c) && $past(dout_en)) |-> (dout_en && $stable(dout)));

    p_chain_block_r10: assert property (@(posedge clk) disable iff (rst)
        (!iei || (pending != '0) || (in_svc != '0)) |-> !ieo);

    p_release_r12: assert property (@(posedge clk) disable iff (rst)
        ioreq_n |-> !dout_en);
endmodule

bind tmr_bus_decoder tbd_checker #(.NCH(NCH), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ioreq_n(ioreq_n), .rd_n(rd_n),
    .m1_n(m1_n), .iei(iei), .ieo(ieo), .dout_en(dout_en), .dout(dout),
    .pending(pending), .in_svc(in_svc), .win_idx(win_idx), .ack_hold(ack_hold)
);

// File: tb/tb_tmr_bus_decoder.sv
module tb_tmr_bus_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ioreq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
    logic [1:0] ch_sel = '0;
    logic [7:0] din = '0;
    logic [3:0] tick = '0;
    logic       iei = 1'b1, isr_done = 1'b0;
    logic [7:0] dout;
    logic       dout_en, ieo;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        string      req;
        bit         is_ieo;
        bit         en;
        logic [7:0] data;
    } exp_t;

    exp_t q[$];
    event sample_ev;

    always #10 clk = ~clk;

    tmr_bus_decoder dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ioreq_n(ioreq_n), .rd_n(rd_n),
        .m1_n(m1_n), .ch_sel(ch_sel), .din(din), .tick(tick), .iei(iei),
        .isr_done(isr_done), .dout(dout), .dout_en(dout_en), .ieo(ieo)
    );

    // monitor: pop expectation and compare with the ports
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (e.is_ieo) begin
                    if (ieo !== e.en) begin
                        bad++;
                        $display("FAIL %s ieo actual=%b expected=%b", e.req, ieo, e.en);
                    end
                end else if (dout_en !== e.en || (e.en && dout !== e.data)) begin
                    bad++;
                    $display("FAIL %s en/data actual=%b/%h expected=%b/%h",
                             e.req, dout_en, dout, e.en, e.data);
                end
            end
        end
    end

    task automatic expect_bus(string req, bit en, logic [7:0] data);
        exp_t e;
        e.req = req; e.is_ieo = 1'b0; e.en = en; e.data = data;
        q.push_back(e);
        ->sample_ev;
        #1;
    endtask

    task automatic expect_ieo(string req, bit v);
        exp_t e;
        e.req = req; e.is_ieo = 1'b1; e.en = v; e.data = '0;
        q.push_back(e);
        ->sample_ev;
        #1;
    endtask

    task automatic go_idle();
        cs_n = 1'b1; ioreq_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1;
    endtask

    task automatic bus_write(logic [1:0] sel, logic [7:0] d, int hold);
        @(negedge clk);
        ch_sel = sel; din = d; cs_n = 1'b0; ioreq_n = 1'b0; rd_n = 1'b1; m1_n = 1'b1;
        repeat (hold) @(posedge clk);
        @(negedge clk);
        go_idle();
    endtask

    task automatic check_read(string req, logic [1:0] sel, logic [7:0] exp_v);
        @(negedge clk);
        ch_sel = sel; cs_n = 1'b0; ioreq_n = 1'b0; rd_n = 1'b0; m1_n = 1'b1;
        #5;
        expect_bus(req, 1'b1, exp_v);
        @(negedge clk);
        go_idle();
    endtask

    task automatic do_tick(int k, int n);
        @(negedge clk);
        tick[k] = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick = '0;
    endtask

    // acknowledge held two clocks; sampled in both
    task automatic check_ack(string req, bit en, logic [7:0] v);
        @(negedge clk);
        m1_n = 1'b0; ioreq_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
        #5;
        expect_bus(req, en, v);
        @(negedge clk);
        #5;
        expect_bus(req, en, v);
        @(negedge clk);
        go_idle();
    endtask

    task automatic pulse_done();
        @(negedge clk);
        isr_done = 1'b1;
        @(negedge clk);
        isr_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        expect_bus("R12 reset release", 1'b0, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        #5;
        expect_ieo("R10 idle chain", 1'b1);
        check_read("R12 reset count", 2'd1, 8'h00);

        // R1: control word held 3 clocks must commit only once
        bus_write(2'd0, 8'h85, 3);
        check_read("R1 single commit", 2'd0, 8'h00);
        // R12: no drive during write cycle
        @(negedge clk);
        ch_sel = 2'd0; din = 8'h05; cs_n = 1'b0; ioreq_n = 1'b0; rd_n = 1'b1; m1_n = 1'b1;
        #5;
        expect_bus("R12 write no drive", 1'b0, 8'h00);
        @(negedge clk);
        go_idle();
        // that write loaded the time constant 5 (R4)
        check_read("R4 time constant", 2'd0, 8'h05);

        // R5: base from channel 0, plain write to channel 2 ignored
        bus_write(2'd0, 8'hA0, 1);
        bus_write(2'd2, 8'h50, 1);

        // R3: fetch leaves bus released and writes nothing
        @(negedge clk);
        ch_sel = 2'd0; din = 8'h11; m1_n = 1'b0; rd_n = 1'b0; ioreq_n = 1'b1; cs_n = 1'b0;
        #5;
        expect_bus("R3 fetch quiet", 1'b0, 8'h00);
        @(negedge clk);
        go_idle();
        check_read("R3 fetch no write", 2'd0, 8'h05);

        bus_write(2'd1, 8'h05, 1);
        bus_write(2'd1, 8'h02, 1);
        bus_write(2'd2, 8'h85, 1);
        bus_write(2'd2, 8'h03, 1);

        do_tick(0, 4);
        check_read("R6 decrement", 2'd0, 8'h01);
        expect_ieo("R10 not yet pending", 1'b1);
        do_tick(0, 1);
        check_read("R6 reload", 2'd0, 8'h05);
        expect_ieo("R10 pending blocks", 1'b0);
        do_tick(1, 2);
        check_read("R6 reload no ie", 2'd1, 8'h02);
        do_tick(2, 3);

        @(negedge clk);
        iei = 1'b0;
        check_ack("R8 no priority", 1'b0, 8'h00);
        @(negedge clk);
        iei = 1'b1;

        check_ack("R7 ch0 vector", 1'b1, 8'hA0);
        check_ack("R9 next winner ch2", 1'b1, 8'hA4);
        check_ack("R8 none pending", 1'b0, 8'h00);

        #5;
        expect_ieo("R10 in service blocks", 1'b0);
        pulse_done();
        #5;
        expect_ieo("R11 one retired", 1'b0);
        pulse_done();
        #5;
        expect_ieo("R11 all retired", 1'b1);
        @(negedge clk);
        iei = 1'b0;
        #5;
        expect_ieo("R10 iei low", 1'b0);
        @(negedge clk);
        iei = 1'b1;

        repeat (2) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule